// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the synchronized pins of a serial peripheral slave and the slave's shift engine. It lets the bus master pause a transfer through an active-low pause input without deselecting the slave. While the pause is in force, the engine sees no clock-edge strobes, so its bit counter and shift registers keep their positions. The serial output driver is disabled, and the data input is never sampled.

A pause begins on a falling edge of the pause input and ends on a rising edge. Either change takes effect only while the serial clock is low. When the edge arrives with the clock high, the change is remembered and carried out at the first sampled cycle in which the clock is low. The pause only has meaning while chip select is active. If chip select is released during a pause, the engine receives a one-cycle reset and the controller returns to running.

All inputs are assumed to be synchronized to `clk` already. Clock edges are found by comparing each sample with the previous one.

Top module: `spi_pause_ctrl`

## Requirements
- R1: While reset is asserted, both strobe outputs and `eng_rst_o` are 0, and `so_oe_o` equals `eng_so_oe_i` (running state).
- R2: If `hold_n_i` changes from 1 to 0 in a cycle where `cs_n_i`=0 and `sclk_i`=0, the pause is in force from the next cycle.
- R3: If that falling edge arrives with `sclk_i`=1, entry waits. Strobes still pass until the first cycle with `sclk_i`=0, and the pause is in force from the cycle after that.
- R4: During a pause, a change of `hold_n_i` from 0 to 1 with `sclk_i`=0 ends the pause from the next cycle.
- R5: If that rising edge arrives with `sclk_i`=1, the exit waits until the first cycle with `sclk_i`=0. Running resumes the cycle after that.
- R6: While running, `sclk_rise_o` is 1 for exactly the cycle in which `sclk_i` is first sampled 1 after a 0, and `sclk_fall_o` behaves the same way for 1 to 0. While paused, both are 0.
- R7: `so_oe_o` is 0 while paused and equals `eng_so_oe_i` while running.
- R8: If `cs_n_i` is 1 in a paused cycle, `eng_rst_o` is 1 in that cycle and the controller is running from the next cycle.
- R9: A falling edge of `hold_n_i` while `cs_n_i`=1 does not start a pause. Pulling `cs_n_i` low afterwards with `hold_n_i` still low does not start one either.
- R10: A pending entry is dropped if `hold_n_i` returns to 1 before `sclk_i` is sampled low.
- R11: `eng_rst_o` is never 1 while the controller is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs_n_i | input | 1 | Synchronized chip select, active low |
| sclk_i | input | 1 | Synchronized serial clock level |
| hold_n_i | input | 1 | Synchronized pause request, active low |
| eng_so_oe_i | input | 1 | Output enable requested by the engine |
| sclk_rise_o | output | 1 | Serial clock rising strobe to the engine |
| sclk_fall_o | output | 1 | Serial clock falling strobe to the engine |
| eng_rst_o | output | 1 | One-cycle engine reset on deselect during a pause |
| so_oe_o | output | 1 | Output enable for the serial output pad |

## Verification
The strobes, the engine reset and the output enable depend on the current sampled inputs and the registered pause state, so they are due in the same cycle as the input change. A change of the pause state itself becomes visible one cycle later. The bench drives inputs on the falling clock edge and samples outputs 1 ns later, before the next rising edge. Each check therefore reads the cycle's combinational response against the state latched at the previous edge, and entry or exit checks look one cycle after the qualifying input.

// File: rtl/spi_pause_pkg.sv
package spi_pause_pkg;
  typedef enum logic {
    PS_RUN  = 1'b0,
    PS_HELD = 1'b1
  } pause_st_e;
endpackage

// File: rtl/spi_pause_edges.sv
// Edge finder for the sampled serial clock and pause request.
module spi_pause_edges #(
  parameter bit SCLK_IDLE = 1'b0,
  parameter bit HOLD_IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic hold_n_i,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic hold_fall,
  output logic hold_rise
);
  logic sclk_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= SCLK_IDLE;
      hold_q <= HOLD_IDLE;
    end else begin
      sclk_q <= sclk_i;
      hold_q <= hold_n_i;
    end
  end

  always_comb begin
    sclk_rise = sclk_i & ~sclk_q;
    sclk_fall = ~sclk_i & sclk_q;
    hold_fall = ~hold_n_i & hold_q;
    hold_rise = hold_n_i & ~hold_q;
  end
endmodule

// File: rtl/spi_pause_fsm.sv
// Two-state pause machine with deferred entry and exit flags.
module spi_pause_fsm
  import spi_pause_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cs_n_i,
  input  logic      sclk_i,
  input  logic      hold_n_i,
  input  logic      hold_fall,
  input  logic      hold_rise,
  output pause_st_e state_o,
  output logic      eng_rst_o
);
  pause_st_e st_q, st_d;
  logic      enter_pend_q, enter_pend_d;
  logic      exit_pend_q, exit_pend_d;
  logic      entry_req, exit_req;

  always_comb begin
    entry_req    = ~cs_n_i & ~hold_n_i & (hold_fall | enter_pend_q);
    exit_req     = hold_n_i & (hold_rise | exit_pend_q);
    st_d         = st_q;
    enter_pend_d = 1'b0;
    exit_pend_d  = 1'b0;
    eng_rst_o    = 1'b0;
    unique case (st_q)
      PS_RUN: begin
        if (entry_req) begin
          if (sclk_i) enter_pend_d = 1'b1;
          else        st_d         = PS_HELD;
        end
      end
      PS_HELD: begin
        if (cs_n_i) begin
          eng_rst_o = 1'b1;
          st_d      = PS_RUN;
        end else if (exit_req) begin
          if (sclk_i) exit_pend_d = 1'b1;
          else        st_d        = PS_RUN;
        end
      end
      default: st_d = PS_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= PS_RUN;
      enter_pend_q <= 1'b0;
      exit_pend_q  <= 1'b0;
    end else begin
      st_q         <= st_d;
      enter_pend_q <= enter_pend_d;
      exit_pend_q  <= exit_pend_d;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/spi_pause_gate.sv
// Masks engine strobes and the output enable while paused.
module spi_pause_gate (
  input  logic held_i,
  input  logic sclk_rise,
  input  logic sclk_fall,
  input  logic eng_so_oe_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic so_oe_o
);
  always_comb begin
    sclk_rise_o = sclk_rise & ~held_i;
    sclk_fall_o = sclk_fall & ~held_i;
    so_oe_o     = eng_so_oe_i & ~held_i;
  end
endmodule

// File: rtl/spi_pause_ctrl.sv
module spi_pause_ctrl
  import spi_pause_pkg::*;
#(
  parameter bit SCLK_IDLE = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sclk_i,
  input  logic hold_n_i,
  input  logic eng_so_oe_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic eng_rst_o,
  output logic so_oe_o
);
  logic      s_rise, s_fall, h_fall, h_rise;
  pause_st_e pause_st;
  logic      held_w;

  spi_pause_edges #(.SCLK_IDLE(SCLK_IDLE), .HOLD_IDLE(1'b1)) u_edges (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .hold_n_i(hold_n_i),
    .sclk_rise(s_rise), .sclk_fall(s_fall),
    .hold_fall(h_fall), .hold_rise(h_rise)
  );

  spi_pause_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
    .hold_n_i(hold_n_i), .hold_fall(h_fall), .hold_rise(h_rise),
    .state_o(pause_st), .eng_rst_o(eng_rst_o)
  );

  assign held_w = (pause_st == PS_HELD);

  spi_pause_gate u_gate (
    .held_i(held_w), .sclk_rise(s_rise), .sclk_fall(s_fall),
    .eng_so_oe_i(eng_so_oe_i), .sclk_rise_o(sclk_rise_o),
    .sclk_fall_o(sclk_fall_o), .so_oe_o(so_oe_o)
  );
endmodule

// File: rtl/spi_pause_ctrl_chk.sv
module spi_pause_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n_i,
  input logic sclk_i,
  input logic hold_n_i,
  input logic held,
  input logic sclk_rise_o,
  input logic sclk_fall_o,
  input logic eng_rst_o,
  input logic so_oe_o
);
  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && $fell(hold_n_i) && !sclk_i && !cs_n_i) |=> held);

  assert_exit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && $rose(hold_n_i) && !sclk_i && !cs_n_i) |=> !held);

  assert_no_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> (!sclk_rise_o && !sclk_fall_o));

  assert_oe_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe_o);

  assert_rst_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rst_o |=> !held);

  assert_desel_no_enter_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && cs_n_i) |=> !held);

  assert_no_rst_run_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !held |-> !eng_rst_o);
endmodule

bind spi_pause_ctrl spi_pause_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n_i), .sclk_i(sclk_i),
  .hold_n_i(hold_n_i), .held(held_w), .sclk_rise_o(sclk_rise_o),
  .sclk_fall_o(sclk_fall_o), .eng_rst_o(eng_rst_o), .so_oe_o(so_oe_o)
);

// File: tb/spi_pause_ctrl_bench.sv
module spi_pause_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n, cs_n, sclk, hold_n, eng_oe;
  logic rise, fall, erst, oe;
  int   n_checks, n_errors;

  spi_pause_ctrl u_spi_pause_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk),
    .hold_n_i(hold_n), .eng_so_oe_i(eng_oe), .sclk_rise_o(rise),
    .sclk_fall_o(fall), .eng_rst_o(erst), .so_oe_o(oe)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string nm, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, nm, got, exp, $time);
    end
  endtask

  // drive at falling edge, settle, outputs readable before next rising edge
  task automatic drv(input logic c, input logic s, input logic h);
    @(negedge clk);
    cs_n = c; sclk = s; hold_n = h;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; hold_n = 1'b1; eng_oe = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "rise", rise, 1'b0);
    chk("R1", "fall", fall, 1'b0);
    chk("R1", "erst", erst, 1'b0);
    chk("R1", "oe", oe, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // bench-side behavioural model for the sweep
  logic m_held, m_pe, m_px, m_sq, m_hq;

  initial begin
    n_checks = 0; n_errors = 0;
    do_reset();

    // R2 / R6 / R4 : immediate entry and exit
    drv(0, 0, 1);
    drv(0, 0, 0); chk("R2", "oe same cycle", oe, 1'b1);
    drv(0, 0, 0); chk("R2", "oe paused", oe, 1'b0);
    drv(0, 1, 0); chk("R6", "rise masked", rise, 1'b0);
    drv(0, 0, 0); chk("R6", "fall masked", fall, 1'b0);
    drv(0, 0, 1); chk("R4", "oe exit cycle", oe, 1'b0);
    drv(0, 0, 1); chk("R4", "oe resumed", oe, 1'b1);
    chk("R7", "oe follows engine", oe, eng_oe);
    drv(0, 1, 1); chk("R6", "rise passes", rise, 1'b1);
    drv(0, 1, 1); chk("R6", "rise single cycle", rise, 1'b0);

    // R3 : deferred entry with sclk high
    drv(0, 1, 0); chk("R3", "oe pending", oe, 1'b1);
    drv(0, 1, 0); chk("R3", "oe still pending", oe, 1'b1);
    drv(0, 0, 0); chk("R3", "fall passes", fall, 1'b1);
    drv(0, 0, 0); chk("R3", "oe paused", oe, 1'b0);

    // R5 : deferred exit with sclk high
    drv(0, 1, 0); chk("R6", "rise masked", rise, 1'b0);
    drv(0, 1, 1); chk("R5", "oe pending", oe, 1'b0);
    drv(0, 1, 1); chk("R5", "oe still paused", oe, 1'b0);
    drv(0, 0, 1); chk("R5", "fall masked", fall, 1'b0);
    drv(0, 0, 1); chk("R5", "oe resumed", oe, 1'b1);

    // R10 : cancelled pending entry
    drv(0, 1, 1); chk("R6", "rise passes", rise, 1'b1);
    drv(0, 1, 0);
    drv(0, 1, 1);
    drv(0, 0, 1); chk("R10", "fall passes", fall, 1'b1);
    drv(0, 0, 1); chk("R10", "not paused", oe, 1'b1);

    // R8 : deselect during pause
    drv(0, 0, 0);
    drv(0, 0, 0); chk("R8", "paused", oe, 1'b0);
    drv(1, 0, 0); chk("R8", "erst pulse", erst, 1'b1);
    drv(1, 0, 0); chk("R8", "erst one cycle", erst, 1'b0);
    chk("R8", "running after reset", oe, 1'b1);
    drv(0, 0, 0); chk("R9", "no entry without new edge", oe, 1'b1);
    drv(0, 0, 0); chk("R9", "still running", oe, 1'b1);

    // R9 / R11 : edge while deselected
    drv(1, 0, 1);
    drv(1, 0, 0); chk("R11", "erst while running", erst, 1'b0);
    drv(1, 0, 0); chk("R9", "no pause while deselected", oe, 1'b1);
    drv(0, 0, 0); chk("R9", "select with hold low", oe, 1'b1);
    drv(0, 1, 0); chk("R9", "rise passes", rise, 1'b1);
    drv(1, 0, 1); chk("R11", "deselect running", erst, 1'b0);

    // sweep against model
    do_reset();
    m_held = 0; m_pe = 0; m_px = 0; m_sq = 0; m_hq = 1;
    begin
      logic [15:0] lf;
      lf = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        logic c, s, h, e, er, ex, xr, xx;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        c = (lf[7:4] == 4'h0);
        s = lf[0];
        h = lf[9] | (lf[11] & lf[3]);
        e = lf[5];
        @(negedge clk);
        cs_n = c; sclk = s; hold_n = h; eng_oe = e;
        #1;
        chk("R6", "sweep rise", rise, s & ~m_sq & ~m_held);
        chk("R6", "sweep fall", fall, ~s & m_sq & ~m_held);
        chk("R7", "sweep oe", oe, e & ~m_held);
        chk(m_held ? "R8" : "R11", "sweep erst", erst, m_held & c);
        er = ~c & ~h & (m_pe | (m_hq & ~h));
        ex = h & (m_px | (~m_hq & h));
        xr = 1'b0; xx = 1'b0;
        if (!m_held) begin
          if (er && s) xr = 1'b1;
          else if (er) m_held = 1'b1;
        end else if (c) m_held = 1'b0;
        else if (ex) begin
          if (s) xx = 1'b1;
          else   m_held = 1'b0;
        end
        m_pe = xr; m_px = xx; m_sq = s; m_hq = h;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule